// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces, one beat at a time, the column addresses of an SDRAM read or write burst. A controller presents a starting column, a burst length code and an ordering choice (linear or interleaved) with a one-cycle start strobe. From the next cycle the generator shows the first column. It moves to the following column on every cycle in which the step input is high, and it flags the final beat.

For burst lengths of two, four and eight, the columns stay inside the aligned block that holds the starting column. The low bits of the column walk that block either by modular increment or by XOR with the beat number, and the high bits stay fixed. A full-page burst covers all 1024 columns of the 10-bit column space. It runs linearly from the start, wraps from 1023 to 0 and keeps going until an abort arrives. A request the block cannot serve raises a one-cycle error flag and produces no addresses. Such a request is an interleaved full page or a reserved length code.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is held and in the first cycle after it, valid_o, last_o and err_o are low.
- R2: An accepted start makes valid_o high in the next cycle, with col_o equal to the starting column.
- R3: Length codes are 0 = one beat, 1 = two, 2 = four, 3 = eight and 7 = full page. Codes 4, 5 and 6 are reserved. A start with a reserved code raises err_o for exactly one cycle and does not raise valid_o.
- R4: In linear order with burst length BL, beat k gives a low field of (start + k) mod BL. The bits above that field keep the start's value.
- R5: In interleaved order with burst length BL, beat k gives a low field of (start XOR k). The bits above that field keep the start's value.
- R6: The beat advances by one at each clock edge where step_i is high while valid_o is high. Without step_i, col_o holds its value.
- R7: last_o is high exactly on beat BL-1. A step on that beat drops valid_o in the next cycle.
- R8: A one-beat burst shows only the starting column, with last_o high on that beat.
- R9: A full-page burst gives start + k mod 1024. It reaches the start column again after 1024 steps, never raises last_o and stays valid until aborted.
- R10: A start asking for an interleaved full page raises err_o for one cycle and generates no addresses.
- R11: abort_i drops valid_o in the next cycle. It overrides a start or a step in the same cycle.
- R12: An accepted start during a burst restarts at the new starting column with the new length and order.
- R13: A rejected start during a burst leaves that burst's column and beat untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe, one cycle |
| start_col_i | input | 10 | Starting column |
| len_code_i | input | 3 | Burst length code (see R3) |
| ilv_i | input | 1 | 1 = interleaved order, 0 = linear |
| step_i | input | 1 | Advance to the next beat |
| abort_i | input | 1 | End the current burst |
| col_o | output | 10 | Current column address |
| valid_o | output | 1 | A burst is active and col_o is meaningful |
| last_o | output | 1 | Current beat is the final one |
| err_o | output | 1 | Previous cycle's start was rejected |

## Verification
Any fault in the stored start column, block mask or order bit shows up on col_o in the first cycle after the start or after the next step. That address is checked against a model computed from the requirements. A beat counter that is off by one moves last_o to the wrong beat, or keeps valid_o high one step too long, within at most eight steps. A full-page count error shows when the address fails to return to the start column after 1024 steps. A wrongly accepted or rejected request is caught by err_o and valid_o one cycle after the strobe.

// File: rtl/colgen_pkg.sv
// Shared definitions for the burst column generator.
// Assumes a 3-bit length code; codes not listed are reserved.
package colgen_pkg;
    localparam int LEN_CODE_W = 3;

    typedef enum logic [LEN_CODE_W-1:0] {
        LEN_1    = 3'd0,
        LEN_2    = 3'd1,
        LEN_4    = 3'd2,
        LEN_8    = 3'd3,
        LEN_PAGE = 3'd7
    } len_code_e;
endpackage

// File: rtl/colgen_decode.sv
// Turns a length code and order choice into an in-block mask and a
// full-page flag, and judges whether the request can be served.
// Assumes COL_W >= 3 so an eight-beat block fits in the column.
module colgen_decode
    import colgen_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [LEN_CODE_W-1:0] len_code_i,
    input  logic                  ilv_i,
    output logic [COL_W-1:0]      mask_o,
    output logic                  full_o,
    output logic                  ok_o
);
    localparam logic [COL_W-1:0] ALL_ONES = '1;

    // Map the length code to an offset mask; reject reserved or unsupported cases.
    always_comb begin
        mask_o = '0;
        full_o = 1'b0;
        ok_o   = 1'b1;
        case (len_code_i)
            LEN_1:    mask_o = '0;
            LEN_2:    mask_o = COL_W'(1);
            LEN_4:    mask_o = COL_W'(3);
            LEN_8:    mask_o = COL_W'(7);
            LEN_PAGE: begin
                mask_o = ALL_ONES;
                full_o = 1'b1;
                ok_o   = ~ilv_i;
            end
            default:  ok_o = 1'b0;
        endcase
    end

    // R3: a reserved code always gives a zero mask with no full-page flag
    always_comb begin
        if (!ok_o && !full_o)
            assert_reserved_zero_mask_R3: assert (mask_o == '0);
    end
endmodule

// File: rtl/colgen_ctrl.sv
// Burst sequencing: holds the active flag and the beat counter and
// decides the final beat. Assumes mask_i and full_i are stable during a burst.
module colgen_ctrl #(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic             abort_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             full_i,
    output logic             valid_o,
    output logic [COL_W-1:0] beat_o,
    output logic             last_o
);
    logic             valid_q;
    logic [COL_W-1:0] beat_q;

    assign last_o = valid_q && !full_i && (beat_q == mask_i);

    // Active flag and beat counter; abort dominates load, which dominates step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            beat_q  <= '0;
        end else if (abort_i) begin
            valid_q <= 1'b0;
        end else if (load_i) begin
            valid_q <= 1'b1;
            beat_q  <= '0;
        end else if (valid_q && step_i) begin
            if (last_o)
                valid_q <= 1'b0;
            beat_q <= beat_q + COL_W'(1);
        end
    end

    assign valid_o = valid_q;
    assign beat_o  = beat_q;

    assert_abort_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> !valid_q);
    assert_load_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !abort_i) |=> (valid_q && beat_q == '0));
    assert_step_on_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && step_i && !load_i) |=> !valid_q);
    assert_page_never_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        full_i |-> !last_o);
    assert_hold_without_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !step_i && !load_i && !abort_i) |=> (valid_q && $stable(beat_q)));
endmodule

// File: rtl/colgen_addr.sv
// Stores the accepted burst parameters and forms the column of the
// current beat: linear order by modular add, interleaved by XOR,
// both confined to the mask. Assumes full page is only linear.
module colgen_addr #(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             full_i,
    input  logic             ilv_i,
    input  logic [COL_W-1:0] beat_i,
    output logic [COL_W-1:0] mask_o,
    output logic             full_o,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] start_q;
    logic [COL_W-1:0] mask_q;
    logic             full_q;
    logic             ilv_q;
    logic [COL_W-1:0] offs;

    // Capture the parameters of an accepted burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            mask_q  <= '0;
            full_q  <= 1'b0;
            ilv_q   <= 1'b0;
        end else if (load_i) begin
            start_q <= start_col_i;
            mask_q  <= mask_i;
            full_q  <= full_i;
            ilv_q   <= ilv_i;
        end
    end

    // Offset within the block for this beat, then merge with the fixed high bits.
    always_comb begin
        offs  = ilv_q ? (start_q ^ beat_i) : (start_q + beat_i);
        col_o = (start_q & ~mask_q) | (offs & mask_q);
    end

    assign mask_o = mask_q;
    assign full_o = full_q;

    assert_params_held_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(start_q) && $stable(mask_q) && $stable(ilv_q)));
    assert_no_ilv_page_R10: assert property (@(posedge clk) disable iff (!rst_n)
        full_q |-> !ilv_q);
endmodule

// File: rtl/sdram_burst_colgen.sv
// Top level of the burst column generator: decodes a start request,
// rejects unsupported ones with a one-cycle error, and steps the
// column sequence. Assumes step_i is only meaningful while valid_o.
module sdram_burst_colgen
    import colgen_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [COL_W-1:0]      start_col_i,
    input  logic [LEN_CODE_W-1:0] len_code_i,
    input  logic                  ilv_i,
    input  logic                  step_i,
    input  logic                  abort_i,
    output logic [COL_W-1:0]      col_o,
    output logic                  valid_o,
    output logic                  last_o,
    output logic                  err_o
);
    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic             dec_ok;
    logic             load;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] run_mask;
    logic             run_full;
    logic             err_q;

    colgen_decode #(.COL_W(COL_W)) u_decode (
        .len_code_i (len_code_i),
        .ilv_i      (ilv_i),
        .mask_o     (dec_mask),
        .full_o     (dec_full),
        .ok_o       (dec_ok)
    );

    assign load = start_i && dec_ok && !abort_i;

    colgen_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .step_i  (step_i),
        .abort_i (abort_i),
        .mask_i  (run_mask),
        .full_i  (run_full),
        .valid_o (valid_o),
        .beat_o  (beat),
        .last_o  (last_o)
    );

    colgen_addr #(.COL_W(COL_W)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .start_col_i (start_col_i),
        .mask_i      (dec_mask),
        .full_i      (dec_full),
        .ilv_i       (ilv_i),
        .beat_i      (beat),
        .mask_o      (run_mask),
        .full_o      (run_full),
        .col_o       (col_o)
    );

    // One-cycle error pulse for a rejected start request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else
            err_q <= start_i && !dec_ok;
    end

    assign err_o = err_q;

    assert_err_after_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(start_i));
    assert_last_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);
endmodule

// File: tb/test_sdram_burst_colgen.sv
module test_sdram_burst_colgen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [9:0] start_col_i = '0;
    logic [2:0] len_code_i = '0;
    logic       ilv_i = 1'b0;
    logic       step_i = 1'b0;
    logic       abort_i = 1'b0;
    logic [9:0] col_o;
    logic       valid_o, last_o, err_o;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sdram_burst_colgen i_sdram_burst_colgen (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .ilv_i(ilv_i), .step_i(step_i), .abort_i(abort_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int blen(input int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 8;
            default: return 1024;
        endcase
    endfunction

    function automatic int exp_col(input int sc, input int n, input bit ilv, input int b);
        int m = n - 1;
        int base = sc & ~m & 1023;
        int off = ilv ? ((sc & m) ^ b) : ((sc & m) + b);
        return base | (off & m);
    endfunction

    // Inputs change at the falling edge; outputs are read at the next falling edge.
    task automatic do_start(input int col, input int code, input bit ilv, input bit abt);
        @(negedge clk);
        start_i = 1'b1; start_col_i = 10'(col); len_code_i = 3'(code);
        ilv_i = ilv; abort_i = abt;
        @(negedge clk);
        start_i = 1'b0; abort_i = 1'b0;
    endtask

    task automatic do_step();
        @(negedge clk);
        step_i = 1'b1;
        @(negedge clk);
        step_i = 1'b0;
    endtask

    // R2 R4 R5 R6 R7 R8: a whole short burst checked beat by beat
    task automatic t_burst(input int col, input int code, input bit ilv);
        int n = blen(code);
        do_start(col, code, ilv, 1'b0);
        for (int b = 0; b < n; b++) begin
            chk(ilv ? "R5 col" : "R4 col", col_o, exp_col(col, n, ilv, b));
            chk("R2 valid", valid_o, 1);
            chk(n == 1 ? "R8 last" : "R7 last", last_o, (b == n - 1) ? 1 : 0);
            do_step();
        end
        chk("R7 valid drops", valid_o, 0);
    endtask

    // R6: without step the column holds
    task automatic t_hold();
        do_start(10'h1F2, 2, 1'b0, 1'b0);
        do_step();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R6 hold col", col_o, exp_col(10'h1F2, 4, 1'b0, 1));
        end
        @(negedge clk); abort_i = 1'b1; @(negedge clk); abort_i = 1'b0;
    endtask

    // R9 R11: full page walk, wrap, return to start, abort
    task automatic t_page();
        do_start(1020, 7, 1'b0, 1'b0);
        for (int b = 0; b < 1024; b++) begin
            if (b < 12 || b > 1018) begin
                chk("R9 col", col_o, (1020 + b) % 1024);
                chk("R9 no last", last_o, 0);
            end
            do_step();
        end
        chk("R9 back to start", col_o, 1020);
        chk("R9 still valid", valid_o, 1);
        @(negedge clk); abort_i = 1'b1; step_i = 1'b1;
        @(negedge clk); abort_i = 1'b0; step_i = 1'b0;
        chk("R11 abort", valid_o, 0);
    endtask

    // R3 R10: rejected requests
    task automatic t_reject();
        for (int c = 4; c < 7; c++) begin
            do_start(10'h055, c, 1'b0, 1'b0);
            chk("R3 err", err_o, 1);
            chk("R3 no valid", valid_o, 0);
            @(negedge clk);
            chk("R3 err one cycle", err_o, 0);
        end
        do_start(10'h100, 7, 1'b1, 1'b0);
        chk("R10 err", err_o, 1);
        chk("R10 no valid", valid_o, 0);
        @(negedge clk);
        chk("R10 err one cycle", err_o, 0);
    endtask

    // R13: rejected start mid-burst leaves it alone
    task automatic t_reject_mid();
        do_start(10'h2A5, 3, 1'b1, 1'b0);
        do_step(); do_step();
        do_start(10'h000, 5, 1'b0, 1'b0);
        chk("R13 err", err_o, 1);
        chk("R13 col kept", col_o, exp_col(10'h2A5, 8, 1'b1, 2));
        do_step();
        chk("R13 beat kept", col_o, exp_col(10'h2A5, 8, 1'b1, 3));
        chk("R13 valid kept", valid_o, 1);
    endtask

    // R12: restart mid-burst; R11: abort beats a start
    task automatic t_restart();
        do_start(10'h3B6, 1, 1'b1, 1'b0);
        chk("R12 new col", col_o, 10'h3B6);
        do_step();
        chk("R12 new order", col_o, exp_col(10'h3B6, 2, 1'b1, 1));
        chk("R12 new length last", last_o, 1);
        do_start(10'h011, 3, 1'b0, 1'b1);
        chk("R11 abort over start", valid_o, 0);
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", valid_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid", valid_o, 0);
        chk("R1 last", last_o, 0);
        chk("R1 err", err_o, 0);
        t_burst(10'h2A5, 3, 1'b0);
        t_burst(10'h2A5, 3, 1'b1);
        t_burst(10'h1F2, 2, 1'b0);
        t_burst(10'h1F2, 2, 1'b1);
        t_burst(10'h0C3, 1, 1'b0);
        t_burst(10'h0C3, 1, 1'b1);
        t_burst(10'h3FF, 0, 1'b0);
        t_hold();
        t_page();
        t_reject();
        t_reject_mid();
        t_restart();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule